// File: doc/BRIEF.md
# Programmable Channel Divider and Phase-Frequency Detector

This block is one channel of a dual-loop frequency synthesizer. The chip places one copy for the receive loop and one for the transmit loop. A programmable counter divides the VCO-rate clock by a 14-bit ratio N. A phase-frequency detector compares each divided tick with a reference tick. The detector drives a charge-pump output with three states. Pump-up and pump-down pulses show whether the divided clock lags or leads. An enable that is low means the output is high-impedance.

A lock monitor watches the width of the pump pulses. It drives an active-low lock flag. The ratio arrives on a parallel port with a one-cycle load strobe. A power-down input stops the divider, the detector and the lock monitor.

The block holds three state machines:
- **Divider:** modes `DV_COUNT` and `DV_HALT`. It goes from `DV_COUNT` to `DV_HALT` while `pwr_down` is high and returns when `pwr_down` falls.
- **Detector:** states `PFD_IDLE`, `PFD_PUMP_UP` and `PFD_PUMP_DN`. A reference-only tick moves `PFD_IDLE` to `PFD_PUMP_UP`. A divider-only tick moves `PFD_IDLE` to `PFD_PUMP_DN`. The opposite tick returns either pump state to `PFD_IDLE`. Coincident ticks leave it in `PFD_IDLE`. Power-down forces `PFD_IDLE`.
- **Lock monitor:** states `LK_OFF`, `LK_HUNT` and `LK_HELD`. It moves from `LK_HUNT` to `LK_HELD` on the eighth clean reference period. A wide pulse sends `LK_HELD` back to `LK_HUNT`. Power-down moves any state to `LK_OFF`, and release moves `LK_OFF` to `LK_HUNT`.

Top module: `synth_channel`

## Requirements
- R1: While running, `div_tick` is a one-cycle pulse that repeats every N clock cycles, where N is the active ratio.
- R2: After reset N is 7215 when `TX_SIDE`=0 and 9966 when `TX_SIDE`=1. The first `div_tick` is high in the cycle after the N-th rising edge that follows reset release.
- R3: A loaded `div_value` below 16 is used as 16. Values from 16 to 16383 are used as given.
- R4: `div_load` stores `div_value` on its edge. The current period still completes at the old length, and the new ratio applies to the periods after the next terminal count.
- R5: From idle, a `div_tick` that arrives without a `ref_tick` raises `pump_dn` and `pump_oe` in the next cycle. They stay high through the cycle in which a `ref_tick` is sampled, and drop in the cycle after.
- R6: From idle, a `ref_tick` that arrives without a `div_tick` raises `pump_up` and `pump_oe` in the next cycle. They stay high until the cycle after a `div_tick` is sampled.
- R7: When both ticks are sampled together from idle, the output stays idle. `pump_oe` low marks the high-impedance state, and `pump_up` and `pump_dn` are never high together.
- R8: `lock_n` is high after reset. It falls in the cycle after the 8th `ref_tick` sampled since the last wide pulse, or since reset or power-down.
- R9: A pump pulse one cycle wide leaves the lock state unchanged. A pulse of 2 or more cycles raises `lock_n` in the cycle after the pulse's second cycle, and the count of clean periods restarts.
- R10: When `pwr_down` is sampled high, from the next cycle there is no `div_tick`, `pump_oe` is low and `lock_n` is high, and `ref_tick` is ignored. After release, the first `div_tick` follows the N-th rising edge counted from the first edge that samples `pwr_down` low, using the last loaded ratio.
- R11: During reset `div_tick`, `pump_up`, `pump_dn` and `pump_oe` are low and `lock_n` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | VCO-rate clock being divided |
| rst_n | input | 1 | Asynchronous active-low reset |
| pwr_down | input | 1 | Stops the channel while high |
| ref_tick | input | 1 | One-cycle reference pulse, synchronous to clk |
| div_load | input | 1 | Strobe that stores div_value |
| div_value | input | DIV_W (14) | New divide ratio |
| div_tick | output | 1 | Divided-clock pulse |
| pump_up | output | 1 | Positive pump pulse, divided clock lagging |
| pump_dn | output | 1 | Negative pump pulse, divided clock leading |
| pump_oe | output | 1 | Pump drive enable; low means high-impedance |
| lock_n | output | 1 | Low while locked |

## Verification
Latencies from a stimulus to each result:
- `div_tick` appears in the cycle after the rising edge on which the counter reaches its terminal count. The bench keeps a queue of the tick cycles it expects, computed from N and the load and power-down times, and pops one entry for every tick it sees.
- Pump outputs change one cycle after the edge that samples a tick.
- `lock_n` falls one cycle after the eighth clean reference tick. It rises one cycle after the second cycle of a wide pulse.

All inputs change at falling edges, and every output is sampled at a falling edge. Each check therefore names an exact cycle count from reset release, with both the cycle before and the cycle after the change tested.

// File: rtl/synth_chan_pkg.sv
package synth_chan_pkg;

    localparam int CHAN_DIV_W    = 14;
    localparam int CHAN_MIN_DIV  = 16;
    localparam int RX_RESET_DIV  = 7215;
    localparam int TX_RESET_DIV  = 9966;

    typedef enum logic {
        DV_COUNT,
        DV_HALT
    } div_mode_t;

    typedef enum logic [1:0] {
        PFD_IDLE,
        PFD_PUMP_UP,
        PFD_PUMP_DN
    } pfd_state_t;

    typedef enum logic [1:0] {
        LK_OFF,
        LK_HUNT,
        LK_HELD
    } lock_state_t;

endpackage

// File: rtl/sc_divider.sv
module sc_divider
    import synth_chan_pkg::*;
#(
    parameter int DIV_W     = CHAN_DIV_W,
    parameter int MIN_DIV   = CHAN_MIN_DIV,
    parameter int DEFAULT_N = RX_RESET_DIV
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             pwr_down,
    input  logic             load,
    input  logic [DIV_W-1:0] value,
    output logic             tick
);

    localparam logic [DIV_W-1:0] FLOOR   = DIV_W'(MIN_DIV);
    localparam logic [DIV_W-1:0] RESET_N = DIV_W'(DEFAULT_N);
    localparam logic [DIV_W-1:0] ONE     = DIV_W'(1);

    div_mode_t        mode;
    logic [DIV_W-1:0] cnt_q;
    logic [DIV_W-1:0] active_q;
    logic [DIV_W-1:0] shadow_q;
    logic [DIV_W-1:0] end_count;
    logic [DIV_W-1:0] clamped;
    logic             wrap;

    // mode selection: power-down halts the counter on the same edge
    always_comb begin
        mode      = pwr_down ? DV_HALT : DV_COUNT;
        end_count = active_q - ONE;
        wrap      = (cnt_q == end_count);
        clamped   = (value < FLOOR) ? FLOOR : value;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q    <= '0;
            active_q <= RESET_N;
            shadow_q <= RESET_N;
            tick     <= 1'b0;
        end else begin
            if (load) begin
                shadow_q <= clamped;
            end
            unique case (mode)
                DV_HALT: begin
                    cnt_q    <= '0;
                    active_q <= shadow_q;
                    tick     <= 1'b0;
                end
                DV_COUNT: begin
                    if (wrap) begin
                        cnt_q    <= '0;
                        active_q <= shadow_q;
                        tick     <= 1'b1;
                    end else begin
                        cnt_q    <= cnt_q + ONE;
                        tick     <= 1'b0;
                    end
                end
            endcase
        end
    end

endmodule

// File: rtl/sc_pfd.sv
module sc_pfd
    import synth_chan_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic pwr_down,
    input  logic ref_tick,
    input  logic fb_tick,
    output logic up,
    output logic dn,
    output logic oe
);

    pfd_state_t state_q;
    pfd_state_t state_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= PFD_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    always_comb begin
        state_d = state_q;
        if (pwr_down) begin
            state_d = PFD_IDLE;
        end else begin
            unique case (state_q)
                PFD_IDLE: begin
                    if (ref_tick && !fb_tick) begin
                        state_d = PFD_PUMP_UP;
                    end else if (fb_tick && !ref_tick) begin
                        state_d = PFD_PUMP_DN;
                    end
                end
                PFD_PUMP_UP: begin
                    if (fb_tick) begin
                        state_d = PFD_IDLE;
                    end
                end
                PFD_PUMP_DN: begin
                    if (ref_tick) begin
                        state_d = PFD_IDLE;
                    end
                end
                default: state_d = PFD_IDLE;
            endcase
        end
    end

    always_comb begin
        up = 1'b0;
        dn = 1'b0;
        oe = 1'b0;
        unique case (state_q)
            PFD_IDLE: begin
            end
            PFD_PUMP_UP: begin
                up = 1'b1;
                oe = 1'b1;
            end
            PFD_PUMP_DN: begin
                dn = 1'b1;
                oe = 1'b1;
            end
            default: begin
            end
        endcase
    end

endmodule

// File: rtl/sc_lock.sv
module sc_lock
    import synth_chan_pkg::*;
#(
    parameter int LOCK_PERIODS = 8,
    parameter int WIDE_LIMIT   = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic pwr_down,
    input  logic ref_tick,
    input  logic pulse_active,
    output logic lock_n
);

    localparam int GW = $clog2(LOCK_PERIODS + 1);
    localparam int WW = $clog2(WIDE_LIMIT + 1);
    localparam logic [GW-1:0] LAST_GOOD = GW'(LOCK_PERIODS - 1);
    localparam logic [GW-1:0] G_ONE     = GW'(1);
    localparam logic [WW-1:0] W_CAP     = WW'(WIDE_LIMIT);
    localparam logic [WW-1:0] W_EDGE    = WW'(WIDE_LIMIT - 1);
    localparam logic [WW-1:0] W_ONE     = WW'(1);

    lock_state_t   state_q;
    lock_state_t   state_d;
    logic [GW-1:0] good_q;
    logic [GW-1:0] good_d;
    logic [WW-1:0] width_q;
    logic          wide;

    // width of the pulse in progress, saturating at the limit
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            width_q <= '0;
        end else if (pulse_active && !pwr_down) begin
            if (width_q != W_CAP) begin
                width_q <= width_q + W_ONE;
            end
        end else begin
            width_q <= '0;
        end
    end

    assign wide = pulse_active && (width_q >= W_EDGE);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= LK_HUNT;
            good_q  <= '0;
        end else begin
            state_q <= state_d;
            good_q  <= good_d;
        end
    end

    always_comb begin
        state_d = state_q;
        good_d  = good_q;
        if (pwr_down) begin
            state_d = LK_OFF;
            good_d  = '0;
        end else begin
            unique case (state_q)
                LK_OFF: begin
                    state_d = LK_HUNT;
                    good_d  = '0;
                end
                LK_HUNT: begin
                    if (wide) begin
                        good_d = '0;
                    end else if (ref_tick) begin
                        if (good_q == LAST_GOOD) begin
                            state_d = LK_HELD;
                            good_d  = '0;
                        end else begin
                            good_d = good_q + G_ONE;
                        end
                    end
                end
                LK_HELD: begin
                    if (wide) begin
                        state_d = LK_HUNT;
                        good_d  = '0;
                    end
                end
                default: begin
                    state_d = LK_HUNT;
                    good_d  = '0;
                end
            endcase
        end
    end

    always_comb begin
        unique case (state_q)
            LK_HELD: lock_n = 1'b0;
            default: lock_n = 1'b1;
        endcase
    end

endmodule

// File: rtl/synth_channel.sv
module synth_channel
    import synth_chan_pkg::*;
#(
    parameter bit TX_SIDE      = 1'b0,
    parameter int DIV_W        = CHAN_DIV_W,
    parameter int MIN_DIV      = CHAN_MIN_DIV,
    parameter int LOCK_PERIODS = 8,
    parameter int WIDE_LIMIT   = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             pwr_down,
    input  logic             ref_tick,
    input  logic             div_load,
    input  logic [DIV_W-1:0] div_value,
    output logic             div_tick,
    output logic             pump_up,
    output logic             pump_dn,
    output logic             pump_oe,
    output logic             lock_n
);

    localparam int RESET_DIV = TX_SIDE ? TX_RESET_DIV : RX_RESET_DIV;

    sc_divider #(
        .DIV_W     (DIV_W),
        .MIN_DIV   (MIN_DIV),
        .DEFAULT_N (RESET_DIV)
    ) u_div (
        .clk      (clk),
        .rst_n    (rst_n),
        .pwr_down (pwr_down),
        .load     (div_load),
        .value    (div_value),
        .tick     (div_tick)
    );

    sc_pfd u_pfd (
        .clk      (clk),
        .rst_n    (rst_n),
        .pwr_down (pwr_down),
        .ref_tick (ref_tick),
        .fb_tick  (div_tick),
        .up       (pump_up),
        .dn       (pump_dn),
        .oe       (pump_oe)
    );

    sc_lock #(
        .LOCK_PERIODS (LOCK_PERIODS),
        .WIDE_LIMIT   (WIDE_LIMIT)
    ) u_lock (
        .clk          (clk),
        .rst_n        (rst_n),
        .pwr_down     (pwr_down),
        .ref_tick     (ref_tick),
        .pulse_active (pump_oe),
        .lock_n       (lock_n)
    );

endmodule

// File: rtl/synth_channel_chk.sv
module synth_channel_chk (
    input logic clk,
    input logic rst_n,
    input logic pwr_down,
    input logic ref_tick,
    input logic div_tick,
    input logic pump_up,
    input logic pump_dn,
    input logic pump_oe,
    input logic lock_n
);

    a_r1_tick_single: assert property (@(posedge clk) disable iff (!rst_n)
        div_tick |=> !div_tick);

    a_r5_fb_first_down: assert property (@(posedge clk) disable iff (!rst_n)
        (!pump_oe && div_tick && !ref_tick && !pwr_down) |=> pump_dn);

    a_r6_ref_first_up: assert property (@(posedge clk) disable iff (!rst_n)
        (!pump_oe && ref_tick && !div_tick && !pwr_down) |=> pump_up);

    a_r7_coincide_idle: assert property (@(posedge clk) disable iff (!rst_n)
        (!pump_oe && ref_tick && div_tick) |=> !pump_oe);

    a_r8_lock_on_ref: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(lock_n) |-> $past(ref_tick));

    a_r9_wide_unlocks: assert property (@(posedge clk) disable iff (!rst_n)
        (pump_oe && $past(pump_oe)) |=> lock_n);

    a_r10_power_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        pwr_down |=> (!div_tick && !pump_oe && lock_n));

endmodule

bind synth_channel synth_channel_chk u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .pwr_down (pwr_down),
    .ref_tick (ref_tick),
    .div_tick (div_tick),
    .pump_up  (pump_up),
    .pump_dn  (pump_dn),
    .pump_oe  (pump_oe),
    .lock_n   (lock_n)
);

// File: tb/sim_synth_channel.sv
module sim_synth_channel;

    localparam int W = 14;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         pwr_down = 1'b0;
    logic         ref_tick = 1'b0;
    logic         div_load = 1'b0;
    logic [W-1:0] div_value = '0;
    logic         div_tick, pump_up, pump_dn, pump_oe, lock_n;
    logic         tx_tick, tx_up, tx_dn, tx_oe, tx_lock_n;

    int checks = 0;
    int failures = 0;
    int cyc;
    int exp_q[$];
    bit ref_en = 1'b0;
    int ref_base = 0;

    always #5 clk = ~clk;

    synth_channel #(.TX_SIDE(1'b0)) u0 (
        .clk(clk), .rst_n(rst_n), .pwr_down(pwr_down), .ref_tick(ref_tick),
        .div_load(div_load), .div_value(div_value), .div_tick(div_tick),
        .pump_up(pump_up), .pump_dn(pump_dn), .pump_oe(pump_oe), .lock_n(lock_n)
    );

    synth_channel #(.TX_SIDE(1'b1)) u1 (
        .clk(clk), .rst_n(rst_n), .pwr_down(1'b0), .ref_tick(1'b0),
        .div_load(1'b0), .div_value('0), .div_tick(tx_tick),
        .pump_up(tx_up), .pump_dn(tx_dn), .pump_oe(tx_oe), .lock_n(tx_lock_n)
    );

    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) cyc <= 0;
        else        cyc <= cyc + 1;
    end

    task automatic chk(input string tag, input int act, input int exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s cyc=%0d actual=%0d expected=%0d", tag, cyc, act, exp);
        end
    endtask

    // driver side of the scoreboard
    task automatic push_ticks(input int first, input int step, input int last);
        for (int t = first; t <= last; t += step) exp_q.push_back(t);
    endtask

    // monitor side: every divided tick must match the next expected cycle (R1)
    always @(negedge clk) begin
        if (rst_n === 1'b1 && div_tick === 1'b1) begin
            if (exp_q.size() == 0) begin
                chk("R1 unexpected div_tick", cyc, -1);
            end else begin
                chk("R1 div_tick cycle", cyc, exp_q.pop_front());
            end
        end
    end

    task automatic adv();
        @(negedge clk);
        ref_tick = ref_en && (cyc >= ref_base) && (((cyc - ref_base) % 16) == 0);
    endtask

    task automatic wait_cyc(input int c);
        while (cyc < c) adv();
    endtask

    task automatic summary();
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        checks++;
        failures++;
        $display("FAIL R1 watchdog actual=running expected=finished");
        summary();
        $finish;
    end

    initial begin
        push_ticks(7215, 16, 7487);
        push_ticks(7507, 20, 7527);
        push_ticks(7580, 20, 9960);

        repeat (3) @(negedge clk);
        chk("R11 reset div_tick", int'(div_tick), 0);
        chk("R11 reset pump_oe", int'(pump_oe), 0);
        chk("R11 reset pump_up", int'(pump_up), 0);
        chk("R11 reset pump_dn", int'(pump_dn), 0);
        chk("R11 reset lock_n", int'(lock_n), 1);
        rst_n = 1'b1;

        wait_cyc(3);
        div_load = 1'b1;
        div_value = W'(5);
        wait_cyc(4);
        div_load = 1'b0;

        wait_cyc(7214);
        chk("R2 no tick before default N", int'(div_tick), 0);
        wait_cyc(7215);
        chk("R2 tick after default N", int'(div_tick), 1);

        wait_cyc(7216);
        chk("R5 pump_dn on lone div tick", int'(pump_dn), 1);
        chk("R5 pump_oe on lone div tick", int'(pump_oe), 1);
        chk("R7 no up with dn", int'(pump_up), 0);
        wait_cyc(7219);
        ref_en = 1'b1;
        ref_base = 7220;
        wait_cyc(7220);
        chk("R5 pump_dn held until ref", int'(pump_dn), 1);
        wait_cyc(7221);
        chk("R5 pump_oe released after ref", int'(pump_oe), 0);

        wait_cyc(7230);
        chk("R3 clamp no early tick", int'(div_tick), 0);
        wait_cyc(7231);
        chk("R3 clamped period 16", int'(div_tick), 1);

        wait_cyc(7270);
        ref_base = 7276;
        wait_cyc(7278);
        chk("R6 pump_up when ref leads", int'(pump_up), 1);
        chk("R6 pump_dn low when ref leads", int'(pump_dn), 0);
        wait_cyc(7280);
        chk("R6 pump_oe released after div", int'(pump_oe), 0);
        chk("R8 unlocked while pulses wide", int'(lock_n), 1);

        wait_cyc(7300);
        ref_base = 7311;
        wait_cyc(7312);
        chk("R7 coincident ticks stay idle", int'(pump_oe), 0);
        wait_cyc(7423);
        chk("R8 not locked before 8th ref", int'(lock_n), 1);
        wait_cyc(7424);
        chk("R8 locked after 8th ref", int'(lock_n), 0);

        wait_cyc(7430);
        ref_base = 7438;
        wait_cyc(7439);
        chk("R9 one-cycle up pulse", int'(pump_up), 1);
        wait_cyc(7440);
        chk("R9 one-cycle pulse ends", int'(pump_up), 0);
        wait_cyc(7456);
        chk("R9 narrow pulses keep lock", int'(lock_n), 0);

        wait_cyc(7460);
        ref_base = 7468;
        wait_cyc(7470);
        chk("R9 lock kept in first wide cycle", int'(lock_n), 0);
        wait_cyc(7471);
        chk("R9 wide pulse drops lock", int'(lock_n), 1);

        wait_cyc(7480);
        div_load = 1'b1;
        div_value = W'(20);
        wait_cyc(7481);
        div_load = 1'b0;
        wait_cyc(7503);
        chk("R4 no short cycle after load", int'(div_tick), 0);
        wait_cyc(7507);
        chk("R4 new ratio after terminal count", int'(div_tick), 1);

        wait_cyc(7530);
        pwr_down = 1'b1;
        wait_cyc(7533);
        chk("R10 ref ignored in power-down", int'(pump_oe), 0);
        chk("R10 lock_n high in power-down", int'(lock_n), 1);
        wait_cyc(7549);
        chk("R10 pump quiet in power-down", int'(pump_up), 0);
        wait_cyc(7560);
        pwr_down = 1'b0;
        wait_cyc(7579);
        chk("R10 no early tick after release", int'(div_tick), 0);
        wait_cyc(7580);
        chk("R10 first tick after release", int'(div_tick), 1);

        wait_cyc(9965);
        chk("R2 transmit default no early tick", int'(tx_tick), 0);
        wait_cyc(9966);
        chk("R2 transmit default 9966", int'(tx_tick), 1);
        wait_cyc(9970);
        chk("R1 all expected ticks seen", exp_q.size(), 0);

        summary();
        $finish;
    end

endmodule